// File: doc/BRIEF.md
# Asynchronous Timer Register Update Bridge

An 8-bit timer/counter with a compare register and a control register. The counter runs either from the system clock or from a separate asynchronous timer clock. The choice is made by a clock-select bit in a status register. Software uses a small register bus in the system domain. Writes land first in holding registers in that domain. In asynchronous mode a toggle handshake then carries each held value into the timer domain, and a per-register update-busy flag shows when the copy is still in flight.

Reads are not all taken from the same place. The counter read returns the live timer value. In asynchronous mode this value is resynchronised through two flops, and a new value is accepted only when both stages agree. Compare and control reads return the holding registers. In synchronous mode writes reach the timer registers on the same edge, and the busy flags stay at zero. The timer drives a compare-match pulse and an overflow pulse, each one timer-clock cycle wide.

Top module: `async_tmr_bridge`

## Requirements
- R1: After reset, every register reads 0 (address 0 counter, 1 compare, 2 control, 3 status), and both pulses are low.
- R2: Status (address 3) is laid out as bit 3 clock select (the only writable bit), bit 2 counter busy, bit 1 compare busy and bit 0 control busy. Bits 7:4 always read 0, and writes to bits 7:4 and 2:0 have no effect.
- R3: With clock select at 1, a write to the counter, compare or control register sets that register's busy flag. The flag reads 1 on the cycle after the write.
- R4: A busy flag stays set until the timer domain has taken the held value. That takes three timer-clock edges for request synchronisation and load, then two system edges for the acknowledge. The timer register then holds the written value.
- R5: With clock select at 0, a write reaches the timer register on the write's own clock edge, and the busy flags stay 0.
- R6: Compare and control reads return the last value written, from the cycle after the write, even while the transfer is busy.
- R7: The counter advances by one on each timer-clock edge while control bits 2:0 are non-zero, and holds while they are zero. A counter write takes priority over counting. In asynchronous mode the system clock does not advance it.
- R8: cmp_pulse is high for the one timer cycle after the counter has counted to a value equal to the compare register.
- R9: ovf_pulse is high for the one timer cycle after the counter has counted from 255 to 0.
- R10: In asynchronous mode a counter read returns the timer value once that value has been stable for three system clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| tclk | input | 1 | Asynchronous timer clock |
| we | input | 1 | Register write strobe |
| addr | input | 2 | Register address: 0 counter, 1 compare, 2 control, 3 status |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr, combinational |
| cmp_pulse | output | 1 | Compare-match pulse, timer domain |
| ovf_pulse | output | 1 | Overflow pulse, timer domain |

## Verification
In synchronous mode the counter, compare pulse and overflow pulse all change on the clock edge that takes a write or a count. The bench drives each write half a cycle early and samples at the following falling edge, against a model that steps once per edge. In asynchronous mode the bench generates the timer clock itself, one pulse at a time. This makes the three-edge load exact: busy is checked still set after two pulses and cleared within a bounded poll after the third. A counter read is taken only after four system edges with the timer clock held still, so the two-flop snapshot has settled.

// File: rtl/async_tmr_bridge.sv
module async_tmr_bridge #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tclk,
  input  logic          we,
  input  logic [1:0]    addr,
  input  logic [CW-1:0] wdata,
  output logic [CW-1:0] rdata,
  output logic          cmp_pulse,
  output logic          ovf_pulse
);
  localparam logic [1:0] A_CNT = 2'd0;
  localparam logic [1:0] A_CMP = 2'd1;
  localparam logic [1:0] A_CTL = 2'd2;
  localparam logic [1:0] A_STS = 2'd3;
  localparam int         EN_W  = 3;
  localparam logic [CW-1:0] TOP = '1;

  // system domain
  logic          as_sel;
  logic [CW-1:0] h_cnt, h_cmp, h_ctl;
  logic [2:0]    req, ak1, ak2;
  logic [CW-1:0] cs1, cs2, c_rd;
  // timer domain
  logic [2:0]    rq1, rq2, rq3;
  logic [CW-1:0] cnt, ocr, ctl;
  logic          cmp_q, ovf_q;

  wire wr_cnt = we && addr == A_CNT;
  wire wr_cmp = we && addr == A_CMP;
  wire wr_ctl = we && addr == A_CTL;
  wire wr_sts = we && addr == A_STS;
  wire [2:0] busy = req ^ ak2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      as_sel <= 1'b0;
      h_cnt  <= '0;
      h_cmp  <= '0;
      h_ctl  <= '0;
      req    <= '0;
      ak1    <= '0;
      ak2    <= '0;
      cs1    <= '0;
      cs2    <= '0;
      c_rd   <= '0;
    end else begin
      if (wr_sts) as_sel <= wdata[3];
      if (wr_cnt) h_cnt <= wdata;
      if (wr_cmp) h_cmp <= wdata;
      if (wr_ctl) h_ctl <= wdata;
      if (as_sel) req <= req ^ {wr_cnt, wr_cmp, wr_ctl};
      ak1 <= rq3;
      ak2 <= ak1;
      cs1 <= cnt;
      cs2 <= cs1;
      if (cs1 == cs2) c_rd <= cs2;
    end
  end

  always_comb begin
    case (addr)
      A_CNT:   rdata = as_sel ? c_rd : cnt;
      A_CMP:   rdata = h_cmp;
      A_CTL:   rdata = h_ctl;
      default: rdata = {{(CW-4){1'b0}}, as_sel, busy};
    endcase
  end

  wire tmr_clk = as_sel ? tclk : clk;
  wire direct  = !as_sel;
  wire [2:0] xfer = rq2 ^ rq3;

  wire          ld_cnt = xfer[2] || (direct && wr_cnt);
  wire [CW-1:0] src_cnt = xfer[2] ? h_cnt : wdata;
  wire [CW-1:0] ocr_nx = xfer[1] ? h_cmp : (direct && wr_cmp) ? wdata : ocr;
  wire [CW-1:0] ctl_nx = xfer[0] ? h_ctl : (direct && wr_ctl) ? wdata : ctl;
  wire          run = ctl[EN_W-1:0] != '0;
  wire [CW-1:0] cnt_inc = cnt + 1'b1;

  always_ff @(posedge tmr_clk or negedge rst_n) begin
    if (!rst_n) begin
      rq1   <= '0;
      rq2   <= '0;
      rq3   <= '0;
      cnt   <= '0;
      ocr   <= '0;
      ctl   <= '0;
      cmp_q <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      rq1 <= req;
      rq2 <= rq1;
      rq3 <= rq2;
      ocr <= ocr_nx;
      ctl <= ctl_nx;
      if (ld_cnt)   cnt <= src_cnt;
      else if (run) cnt <= cnt_inc;
      cmp_q <= run && !ld_cnt && cnt_inc == ocr_nx;
      ovf_q <= run && !ld_cnt && cnt == TOP;
    end
  end

  assign cmp_pulse = cmp_q;
  assign ovf_pulse = ovf_q;

  AST_BUSY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (as_sel && wr_cmp) |=> busy[1]); // R3
  AST_SYNC_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!as_sel && busy == 3'b000) |=> busy == 3'b000); // R5
  AST_CNT_STEP: assert property (@(posedge tmr_clk) disable iff (!rst_n)
    (run && !ld_cnt) |=> cnt == $past(cnt) + 1'b1); // R7
  AST_CMP_MATCH: assert property (@(posedge tmr_clk) disable iff (!rst_n)
    cmp_pulse |-> cnt == ocr); // R8
  AST_OVF_WRAP: assert property (@(posedge tmr_clk) disable iff (!rst_n)
    ovf_pulse |-> cnt == '0); // R9
endmodule

// File: tb/async_tmr_bridge_test.sv
module async_tmr_bridge_test;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0, tclk = 0, we = 0;
  logic [1:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic cmp_pulse, ovf_pulse;
  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] m_cnt = 0, m_ocr = 0, m_ctl = 0;
  logic ec = 0, eo = 0;

  async_tmr_bridge uut (.clk(clk), .rst_n(rst_n), .tclk(tclk), .we(we), .addr(addr),
    .wdata(wdata), .rdata(rdata), .cmp_pulse(cmp_pulse), .ovf_pulse(ovf_pulse));

  always #(CLK_P/2) clk = ~clk;

  task automatic chk(string r, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h t=%0t", r, act, exp, $time);
    end
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0; addr = 0;
  endtask

  // one synchronous-mode cycle with model update and checks
  task automatic cyc(bit wen, logic [1:0] a, logic [7:0] d);
    logic [7:0] v, onew;
    bit runm;
    we = wen; addr = a; wdata = d;
    @(posedge clk);
    runm = m_ctl[2:0] != 0;
    onew = (wen && a == 1) ? d : m_ocr;
    if (wen && a == 0) begin m_cnt = d; ec = 0; eo = 0; end
    else if (runm) begin eo = (m_cnt == 8'hFF); m_cnt = m_cnt + 1; ec = (m_cnt == onew); end
    else begin ec = 0; eo = 0; end
    m_ocr = onew;
    if (wen && a == 2) m_ctl = d;
    @(negedge clk); we = 0;
    rd(0, v); chk("R7 counter", v, m_cnt);
    chk("R8 cmp_pulse", {7'b0, cmp_pulse}, {7'b0, ec});
    chk("R9 ovf_pulse", {7'b0, ovf_pulse}, {7'b0, eo});
    rd(1, v); chk("R6 compare read", v, m_ocr);
    rd(2, v); chk("R6 control read", v, m_ctl);
    rd(3, v); chk("R5 status sync", v, 8'h00);
    addr = 0;
  endtask

  task automatic tpulse();
    tclk = 1; #7; tclk = 0; #23;
  endtask

  // transfer one held value, checking busy bit b (status value includes sel bit)
  task automatic xfer(int b);
    logic [7:0] v;
    @(negedge clk); rd(3, v); chk("R3 busy set", v, 8'h08 | (8'h01 << b));
    tpulse(); tpulse();
    @(negedge clk); rd(3, v); chk("R4 busy held", v, 8'h08 | (8'h01 << b));
    tpulse();
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); rd(3, v);
      if (v == 8'h08) break;
    end
    chk("R4 busy cleared", v, 8'h08);
    addr = 0;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    for (int a = 0; a < 4; a++) begin rd(a[1:0], v); chk("R1 reset reg", v, 8'h00); end
    chk("R1 reset pulses", {6'b0, cmp_pulse, ovf_pulse}, 8'h00);

    wr(3, 8'hF7);
    rd(3, v); chk("R2 status write ignored bits", v, 8'h00);
    addr = 0;

    // directed synchronous corner cases
    @(negedge clk);
    cyc(1, 2, 8'h00); cyc(1, 0, 8'h10);
    for (int i = 0; i < 4; i++) cyc(0, 0, 0);
    cyc(1, 1, 8'h13); cyc(1, 2, 8'h04);
    for (int i = 0; i < 5; i++) cyc(0, 0, 0);
    cyc(1, 0, 8'hFD); cyc(1, 1, 8'h00);
    for (int i = 0; i < 5; i++) cyc(0, 0, 0);
    cyc(1, 0, 8'hFF); cyc(1, 0, 8'h40);

    // constrained random synchronous phase
    for (int i = 0; i < 2000; i++) begin
      int r = $urandom_range(0, 99);
      if (r < 8)       cyc(1, 0, ($urandom_range(0, 3) == 0) ? 8'hFE : 8'($urandom));
      else if (r < 14) cyc(1, 1, m_cnt + 8'($urandom_range(1, 6)));
      else if (r < 18) cyc(1, 2, ($urandom_range(0, 3) == 0) ? 8'h08 : 8'($urandom));
      else             cyc(0, 0, 0);
    end
    cyc(1, 2, 8'h00);

    // asynchronous mode
    wr(3, 8'h08);
    rd(3, v); chk("R2 clock select set", v, 8'h08); addr = 0;
    @(negedge clk); we = 1; addr = 2; wdata = 8'h00; @(negedge clk); we = 0; xfer(0);
    @(negedge clk); we = 1; addr = 0; wdata = 8'hFD; @(negedge clk); we = 0; xfer(2);
    repeat (4) @(negedge clk);
    rd(0, v); chk("R10 async counter read", v, 8'hFD);
    @(negedge clk); we = 1; addr = 1; wdata = 8'hFF; @(negedge clk); we = 0;
    rd(1, v); chk("R6 compare read while busy", v, 8'hFF); addr = 0;
    xfer(1);
    @(negedge clk); we = 1; addr = 2; wdata = 8'h01; @(negedge clk); we = 0;
    rd(2, v); chk("R6 control read while busy", v, 8'h01); addr = 0;
    xfer(0);
    repeat (4) @(negedge clk);
    rd(0, v); chk("R4 counter held after transfers", v, 8'hFD);
    tpulse(); @(negedge clk);
    chk("R8 no cmp at FE", {7'b0, cmp_pulse}, 8'h00);
    tpulse(); @(negedge clk);
    chk("R8 async cmp at FF", {7'b0, cmp_pulse}, 8'h01);
    chk("R9 no ovf at FF", {7'b0, ovf_pulse}, 8'h00);
    tpulse(); @(negedge clk);
    chk("R9 async ovf at wrap", {7'b0, ovf_pulse}, 8'h01);
    chk("R8 cmp ended", {7'b0, cmp_pulse}, 8'h00);
    repeat (20) @(negedge clk);
    rd(0, v); chk("R7 sysclk ignored in async", v, 8'h00);
    tpulse(); repeat (4) @(negedge clk);
    rd(0, v); chk("R10 async count read", v, 8'h01);
    chk("R9 ovf ended", {7'b0, ovf_pulse}, 8'h00);
    addr = 0;

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule